// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between a clocked on-chip bus and an external asynchronous low-power static RAM of 32 Mbit. The RAM works either as 2M words of 16 bits or as 4M bytes, selected by a strap input. In byte mode the RAM's top data pin stops carrying data and becomes the least-significant address bit. The controller accepts one single-beat read or write at a time through a valid/ready handshake. It produces the chip selects, write enable, output enable and byte-lane enables, and drives the data pins through a per-bit output-enable vector. Read data comes back with a one-cycle valid strobe.

All pin timing is counted in whole clock cycles and set by parameters. The defaults assume a 100 MHz clock and the 55 ns grade: a read holds the chip selected with output enable low for 6 cycles. A write uses one address cycle, a 5-cycle write-enable pulse and one recovery cycle. Output enable stays high for the whole write. The controller starts driving write data only from the second cycle of the write pulse, so the RAM has already released the bus. When no access is running, the chip is deselected and sits in standby.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset: `ram_ce_n`=1, `ram_ce2`=0, `ram_we_n`=1, `ram_oe_n`=1, `ram_lb_n`=`ram_ub_n`=1, `ram_dq_oe`[14:0]=0, `req_ready`=1, `rd_valid`=0.
- R2: An accepted read holds `ram_ce_n`=0, `ram_ce2`=1, `ram_oe_n`=0, `ram_we_n`=1 and both lane enables low for RD_CYC cycles. The data pins are sampled at the clock edge that ends the last of these cycles. `rd_valid` is 1 for exactly the following cycle, with the sampled data on `rd_data`.
- R3: An accepted write gives one selected cycle with `ram_we_n`=1, then WP_CYC cycles with `ram_we_n`=0, then one selected recovery cycle with `ram_we_n`=1. `ram_oe_n` stays 1 throughout, and `ram_we_n` and `ram_oe_n` are never both 0.
- R4: `ram_dq_oe`[7:0] is all ones from the second write-pulse cycle through the recovery cycle, and zero at all other times. While it is set, `ram_dq_o`[7:0] carries the write data.
- R5: In word mode a write drives `ram_lb_n` = NOT `req_bmask`[0] (gating data bits 7..0) and `ram_ub_n` = NOT `req_bmask`[1] (gating bits 15..8). Reads drive both lanes low. A lane left disabled keeps its old RAM contents.
- R6: In word mode (`byte_mode`=0) `ram_addr` = `req_addr`[AW-1:0], and `req_addr`[AW] has no effect. `ram_dq_oe`[15:8] follows `ram_dq_oe`[7:0].
- R7: In byte mode (`byte_mode`=1) the following hold:
  - `ram_addr` = `req_addr`[AW:1].
  - `ram_dq_o`[15] = `req_addr`[0], with `ram_dq_oe`[15]=1 at all times and `ram_dq_oe`[14:8]=0.
  - Both lane enables equal NOT `req_bmask`[0] on a write, so a mask of 0 writes nothing.
  - `rd_data` = {8'h00, data bits 7..0}.
- R8: `req_ready` is 1 only while no access runs, and then `ram_ce_n`=1, `ram_ce2`=0 and both lane enables are high. Back-to-back requests are separated by at least one deselected cycle.
- R9: `ram_addr` changes only in a cycle where `ram_we_n` is 1 and was 1 in the cycle before.
- R10: A request presented while `req_ready` is 0 is ignored: it starts no access and changes no RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | Strap: 1 = 8-bit byte organisation, 0 = 16-bit words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW+1 | Byte address (byte mode) or word address in the low AW bits (word mode) |
| req_wdata | input | 16 | Write data; bits 7..0 only in byte mode |
| req_bmask | input | 2 | Write lane mask, bit 0 = low byte, bit 1 = high byte |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 16 | Returned read data |
| ram_addr | output | AW | RAM address pins |
| ram_ce_n | output | 1 | Active-low chip select |
| ram_ce2 | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_lb_n | output | 1 | Active-low enable for data bits 7..0 |
| ram_ub_n | output | 1 | Active-low enable for data bits 15..8 |
| ram_dq_o | output | 16 | Values for the data pins (bit 15 is the extra address bit in byte mode) |
| ram_dq_oe | output | 16 | Per-pin output enable for the data pins |
| ram_dq_i | input | 16 | Values read back from the data pins |

## Verification
The properties assume the `byte_mode` strap changes only while the controller is idle, and that a requester holds its fields steady only up to the accepting edge. The bench changes the strap only between accesses, at the falling clock edge. It drives every request at the falling edge and withdraws it after the accepting edge. Its RAM model answers only while the chip is selected with output enable low and write enable high, and it commits lanes on the rising edge of write enable. This makes lane masking, the byte-mode address bit and ignored requests visible through later reads.

// File: rtl/asram_pkg.sv
package asram_pkg;
   localparam int DQ_W   = 16;
   localparam int LANE_W = DQ_W / 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WSET,
      ST_WPUL,
      ST_WREC
   } seq_st_t;
endpackage

// File: rtl/asram_addr_map.sv
module asram_addr_map
   import asram_pkg::*;
#(
   parameter int AW = 21,
   parameter bit BYTE_MODE_EN = 1'b1
) (
   input  logic              byte_mode,
   input  logic [AW:0]       addr,
   input  logic              is_wr,
   input  logic [DQ_W-1:0]   wdata,
   input  logic [1:0]        bmask,
   output logic [AW-1:0]     map_addr,
   output logic              lsb,
   output logic [1:0]        lane_n,
   output logic [DQ_W-1:0]   dq_wr,
   output logic              byte_act
);
   generate
      if (BYTE_MODE_EN) begin : g_strap
         assign byte_act = byte_mode;
      end else begin : g_word_only
         assign byte_act = 1'b0;
      end
   endgenerate

   always_comb begin
      if (byte_act) begin
         map_addr = addr[AW:1];
         lsb      = addr[0];
         dq_wr    = {addr[0], {(LANE_W-1){1'b0}}, wdata[LANE_W-1:0]};
         lane_n   = is_wr ? {2{~bmask[0]}} : 2'b00;
      end else begin
         map_addr = addr[AW-1:0];
         lsb      = 1'b0;
         dq_wr    = wdata;
         lane_n   = is_wr ? ~bmask : 2'b00;
      end
   end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int RD_CYC = 6,
   parameter int WP_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_rd,
   input  logic start_wr,
   output logic ready,
   output logic sel,
   output logic we_n,
   output logic oe_n,
   output logic drv,
   output logic cap
);
   localparam int CMAX = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
   localparam int CW   = $clog2(CMAX + 1);
   localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
   localparam logic [CW-1:0] WP_LOAD = CW'(WP_CYC - 1);

   seq_st_t       st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start_rd) begin
                  st  <= ST_RD;
                  cnt <= RD_LOAD;
               end else if (start_wr) begin
                  st <= ST_WSET;
               end
            end
            ST_RD: begin
               if (cnt == '0) st <= ST_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            ST_WSET: begin
               st  <= ST_WPUL;
               cnt <= WP_LOAD;
            end
            ST_WPUL: begin
               if (cnt == '0) st <= ST_WREC;
               else           cnt <= cnt - 1'b1;
            end
            ST_WREC: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ready = (st == ST_IDLE);
   assign sel   = (st != ST_IDLE);
   assign we_n  = (st != ST_WPUL);
   assign oe_n  = (st != ST_RD);
   assign drv   = ((st == ST_WPUL) && (cnt != WP_LOAD)) || (st == ST_WREC);
   assign cap   = (st == ST_RD) && (cnt == '0);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int AW     = 21,
   parameter int RD_CYC = 6,
   parameter int WP_CYC = 5,
   parameter int WD_CYC = 3,
   parameter int WC_CYC = 6,
   parameter bit BYTE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [AW:0]       req_addr,
   input  logic [DQ_W-1:0]   req_wdata,
   input  logic [1:0]        req_bmask,
   output logic              rd_valid,
   output logic [DQ_W-1:0]   rd_data,
   output logic [AW-1:0]     ram_addr,
   output logic              ram_ce_n,
   output logic              ram_ce2,
   output logic              ram_we_n,
   output logic              ram_oe_n,
   output logic              ram_lb_n,
   output logic              ram_ub_n,
   output logic [DQ_W-1:0]   ram_dq_o,
   output logic [DQ_W-1:0]   ram_dq_oe,
   input  logic [DQ_W-1:0]   ram_dq_i
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("AW must be at least 2");
      end
      if (RD_CYC < 1) begin : g_bad_rd
         $error("RD_CYC must be at least 1");
      end
      if (WP_CYC < WD_CYC + 1) begin : g_bad_wp
         $error("write pulse must cover one turnaround cycle plus data setup");
      end
      if (WP_CYC + 2 < WC_CYC) begin : g_bad_wc
         $error("write sequence shorter than write cycle time");
      end
   endgenerate

   logic            q_wr;
   logic [AW:0]     q_addr;
   logic [DQ_W-1:0] q_wdata;
   logic [1:0]      q_bmask;
   logic            accept;
   logic            sel, we_n, oe_n, drv, cap;
   logic [AW-1:0]   m_addr;
   logic            m_lsb, bm;
   logic [1:0]      m_lane_n;
   logic [DQ_W-1:0] m_dq;

   assign accept = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_wr    <= 1'b0;
         q_addr  <= '0;
         q_wdata <= '0;
         q_bmask <= '0;
      end else if (accept) begin
         q_wr    <= req_write;
         q_addr  <= req_addr;
         q_wdata <= req_wdata;
         q_bmask <= req_bmask;
      end
   end

   asram_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_rd (accept & ~req_write),
      .start_wr (accept & req_write),
      .ready    (req_ready),
      .sel      (sel),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .drv      (drv),
      .cap      (cap)
   );

   asram_addr_map #(.AW(AW), .BYTE_MODE_EN(BYTE_MODE_EN)) map_i (
      .byte_mode (byte_mode),
      .addr      (q_addr),
      .is_wr     (q_wr),
      .wdata     (q_wdata),
      .bmask     (q_bmask),
      .map_addr  (m_addr),
      .lsb       (m_lsb),
      .lane_n    (m_lane_n),
      .dq_wr     (m_dq),
      .byte_act  (bm)
   );

   assign ram_addr  = m_addr;
   assign ram_ce_n  = ~sel;
   assign ram_ce2   = sel;
   assign ram_we_n  = we_n;
   assign ram_oe_n  = oe_n;
   assign ram_lb_n  = sel ? m_lane_n[0] : 1'b1;
   assign ram_ub_n  = sel ? m_lane_n[1] : 1'b1;
   assign ram_dq_o  = {(bm ? m_lsb : m_dq[DQ_W-1]), m_dq[DQ_W-2:0]};
   assign ram_dq_oe = {(bm | drv), {(LANE_W-1){drv & ~bm}}, {LANE_W{drv}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cap;
         if (cap) rd_data <= bm ? {{LANE_W{1'b0}}, ram_dq_i[LANE_W-1:0]} : ram_dq_i;
      end
   end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int AW = 21
) (
   input logic          clk,
   input logic          rst_n,
   input logic          byte_mode,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rd_valid,
   input logic [AW-1:0] ram_addr,
   input logic          ram_ce_n,
   input logic          ram_ce2,
   input logic          ram_we_n,
   input logic          ram_oe_n,
   input logic          ram_lb_n,
   input logic          ram_ub_n,
   input logic [15:0]   ram_dq_oe
);
   // R3: write enable and output enable never low together
   p_no_we_oe_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram_we_n && !ram_oe_n));

   // R3: write strobe only with both chip selects active
   p_we_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!ram_ce_n && ram_ce2));

   // R4: no drive while the RAM may be driving
   p_drive_not_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_dq_oe[0] |-> ram_oe_n);

   // R4: drivers stay off in the cycle write enable falls
   p_drive_after_we_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n) |-> !ram_dq_oe[0]);

   // R4: drivers still on in the cycle write enable rises
   p_drive_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |-> ram_dq_oe[0]);

   // R2: read strobe lasts one cycle
   p_rd_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R7: unused data pins never driven in byte mode
   p_byte_upper_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_mode |-> (ram_dq_oe[14:8] == 7'd0));

   // R8: idle means standby
   p_ready_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ram_ce_n && !ram_ce2 && ram_lb_n && ram_ub_n));

   // R9: address moves only with write enable high
   p_addr_we_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ram_addr) |-> (ram_we_n && $past(ram_we_n)));
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) chk_i (.*);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb_top;
   localparam int AW = 21;
   localparam int RD = 6;
   localparam int WP = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          byte_mode = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW:0]   req_addr = '0;
   logic [15:0]   req_wdata = '0;
   logic [1:0]    req_bmask = '0;
   logic          rd_valid;
   logic [15:0]   rd_data;
   logic [AW-1:0] ram_addr;
   logic          ram_ce_n, ram_ce2, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n;
   logic [15:0]   ram_dq_o, ram_dq_oe, ram_dq_i;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   asram_ctrl #(.AW(AW), .RD_CYC(RD), .WP_CYC(WP)) dut_i (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
      .rd_valid(rd_valid), .rd_data(rd_data), .ram_addr(ram_addr),
      .ram_ce_n(ram_ce_n), .ram_ce2(ram_ce2), .ram_we_n(ram_we_n),
      .ram_oe_n(ram_oe_n), .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n),
      .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
   );

   // RAM model
   logic [15:0] wmem [64];
   logic [7:0]  bmem [128];
   logic        rd_en;
   logic [6:0]  bidx;
   assign rd_en = !ram_ce_n && ram_ce2 && !ram_oe_n && ram_we_n;
   assign bidx  = {ram_addr[5:0], ram_dq_o[15]};

   always_comb begin
      if (!rd_en)         ram_dq_i = 16'hDEAD;
      else if (byte_mode) ram_dq_i = {8'hEE, bmem[bidx]};
      else                ram_dq_i = wmem[ram_addr[5:0]];
   end

   always @(posedge ram_we_n) begin
      if (rst_n && !ram_ce_n && ram_ce2) begin
         if (byte_mode) begin
            if (!ram_lb_n) bmem[bidx] <= ram_dq_o[7:0];
         end else begin
            if (!ram_lb_n) wmem[ram_addr[5:0]][7:0]  <= ram_dq_o[7:0];
            if (!ram_ub_n) wmem[ram_addr[5:0]][15:8] <= ram_dq_o[15:8];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      chk("R1 ce_n", ram_ce_n, 1);
      chk("R1 ce2", ram_ce2, 0);
      chk("R1 we_n", ram_we_n, 1);
      chk("R1 oe_n", ram_oe_n, 1);
      chk("R1 lanes", {ram_ub_n, ram_lb_n}, 2'b11);
      chk("R1 dq_oe", ram_dq_oe[14:0], 0);
      chk("R1 ready", req_ready, 1);
      chk("R1 rd_valid", rd_valid, 0);
   endtask

   task automatic do_write(input logic [AW:0] a, input logic [15:0] d, input logic [1:0] m,
                           input logic [1:0] exp_lane, input logic [AW-1:0] exp_ra);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_bmask = m;
      @(negedge clk);
      req_valid = 0;
      chk("R3 set ce_n", ram_ce_n, 0);
      chk("R3 set we_n", ram_we_n, 1);
      chk("R4 set no drive", ram_dq_oe[7:0], 0);
      chk("R5 lanes", {ram_ub_n, ram_lb_n}, exp_lane);
      chk("R6 addr", ram_addr, exp_ra);
      if (byte_mode) begin
         chk("R7 a-1 pin", {ram_dq_oe[15], ram_dq_o[15]}, {1'b1, a[0]});
         chk("R7 upper off", ram_dq_oe[14:8], 0);
      end
      for (int k = 0; k < WP; k++) begin
         @(negedge clk);
         chk("R3 pulse we_n", {ram_we_n, ram_oe_n}, 2'b01);
         chk("R4 drive", ram_dq_oe[7:0], (k != 0) ? 8'hFF : 8'h00);
         if (k != 0) chk("R4 data", ram_dq_o[7:0], d[7:0]);
      end
      @(negedge clk);
      chk("R3 recovery", {ram_ce_n, ram_we_n, ram_oe_n}, 3'b011);
      chk("R4 hold drive", ram_dq_oe[7:0], 8'hFF);
      @(negedge clk);
      chk("R8 standby", {ram_ce_n, req_ready}, 2'b11);
      chk("R4 released", ram_dq_oe[7:0], 0);
   endtask

   task automatic do_read(input logic [AW:0] a, input logic [15:0] exp, input logic [AW-1:0] exp_ra);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a;
      for (int k = 0; k < RD; k++) begin
         @(negedge clk);
         req_valid = 0;
         chk("R2 read pins", {ram_ce_n, ram_ce2, ram_oe_n, ram_we_n, ram_ub_n, ram_lb_n}, 6'b010100);
         chk("R2 no strobe", rd_valid, 0);
         chk("R6 addr", ram_addr, exp_ra);
         if (byte_mode) chk("R7 a-1 pin", {ram_dq_oe[15], ram_dq_o[15]}, {1'b1, a[0]});
      end
      @(negedge clk);
      chk("R2 valid", rd_valid, 1);
      chk("R2 data", rd_data, exp);
      chk("R8 idle", {ram_ce_n, req_ready}, 2'b11);
      @(negedge clk);
      chk("R2 single pulse", rd_valid, 0);
   endtask

   task automatic t_word_rw();
      do_write(22'h000005, 16'h1234, 2'b11, 2'b00, 21'h5);
      do_read(22'h000005, 16'h1234, 21'h5);
      do_write(22'h00000A, 16'hBEEF, 2'b11, 2'b00, 21'hA);
      do_read(22'h00000A, 16'hBEEF, 21'hA);
   endtask

   task automatic t_lane_mask();
      do_write(22'h000005, 16'hAB99, 2'b10, 2'b01, 21'h5); // R5 high lane only
      do_read(22'h000005, 16'hAB34, 21'h5);
      do_write(22'h000005, 16'h77CD, 2'b01, 2'b10, 21'h5); // R5 low lane only
      do_read(22'h000005, 16'hABCD, 21'h5);
   endtask

   task automatic t_top_bit_ignored();
      // R6: bit AW of the request does not reach the pins in word mode
      do_write(22'h200007, 16'h5151, 2'b11, 2'b00, 21'h7);
      do_read(22'h000007, 16'h5151, 21'h7);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 22'h00000A;
      repeat (RD + 1) @(negedge clk);
      chk("R8 gap deselected", {ram_ce_n, req_ready, rd_valid}, 3'b111);
      @(negedge clk);
      req_valid = 0;
      chk("R8 second access", ram_ce_n, 0);
      repeat (RD) @(negedge clk);
      chk("R8 second data", {rd_valid, rd_data}, {1'b1, 16'hBEEF});
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 22'h000005;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 22'h000009; req_wdata = 16'hFFFF; req_bmask = 2'b11;
      @(negedge clk);
      req_valid = 0;
      repeat (RD - 2) @(negedge clk);
      chk("R10 read result", {rd_valid, rd_data}, {1'b1, 16'hABCD});
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R10 no extra access", ram_ce_n, 1);
      end
      do_read(22'h000009, 16'h0000, 21'h9);
   endtask

   task automatic t_byte_mode();
      @(negedge clk);
      byte_mode = 1;
      do_write(22'h000007, 16'hFF5A, 2'b01, 2'b00, 21'h3);
      do_write(22'h000006, 16'h00C3, 2'b01, 2'b00, 21'h3);
      do_read(22'h000007, 16'h005A, 21'h3);
      do_read(22'h000006, 16'h00C3, 21'h3);
      // R7: mask bit 0 clear -> both lanes high, byte unchanged
      do_write(22'h000007, 16'h0011, 2'b10, 2'b11, 21'h3);
      do_read(22'h000007, 16'h005A, 21'h3);
      @(negedge clk);
      byte_mode = 0;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) wmem[i] = '0;
      for (int i = 0; i < 128; i++) bmem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_word_rw();
      t_lane_mask();
      t_top_bit_ignored();
      t_back_to_back();
      t_busy_ignore();
      t_byte_mode();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule